// File: doc/BRIEF.md
# Phase Dropout Frequency-Source Supervisor

This block sits beside a three-phase metering front end. It decides which phase drives the line-frequency measurement and which phases take part in zero-crossing counting. Each phase brings two health indications, a zero-crossing timeout flag and a voltage sag flag. A phase with either flag raised is marked dropped. The mark stays set until both flags have stayed low for a programmable recovery window.

Software sets a preferred frequency source and a zero-crossing enable set through a small write port. There are two registers. Address 0 is the source register, with the select code in bits [1:0]. Address 1 is the counting register, with the enable set in bits [5:3]. When the phase that feeds frequency measurement drops out, the block moves the source on its own to the next healthy phase and pulses a notification. The zero-crossing mask it drives never includes a dropped phase. A recovered phase returns to the mask, but the source does not move back to it.

Top module: `phase_dropout_sup`

## Requirements
- R1: After reset the source select is 00 (phase A), the zero-crossing mask is 3'b111 and the switch pulse is low.
- R2: A write to address 0 loads bits [1:0] as the source select, with 00 for A, 01 for B and 10 for C, visible on the cycle after the write edge and raising no switch pulse.
- R3: Writing code 11 to the source select is stored and reported as 00 (phase A). The output select never shows 11.
- R4: A write to address 1 loads bits [5:3] as the zero-crossing enable set (bit 3 for A, bit 4 for B, bit 5 for C). All other data bits, and writes to the other address, leave the set unchanged.
- R5: A phase whose timeout or sag flag is high at a clock edge is dropped from that edge on. Its mask bit (bit 0 A, bit 1 B, bit 2 C) reads 0 from the next cycle.
- R6: When the selected phase is dropped, the select moves one edge later to the first phase that is not dropped, searching in the cyclic order A, B, C and starting after the current phase.
- R7: While all three phases are dropped, the select holds its value and no switch pulse occurs.
- R8: A dropped phase recovers only after both of its flags have been low for RECOVER_CYC consecutive edges. A flag seen again restarts the count. After recovery its mask bit follows the software enable again.
- R9: The switch pulse is high for exactly one cycle, in the cycle when an automatic change first shows on the select. It is never raised by a software write.
- R10: A dropout of a phase that is not selected leaves the select unchanged.
- R11: A software write to the source select takes priority over a failover at the same edge. If the written phase is dropped, failover moves away from it on the following edge.
- R12: Recovery of a phase never moves the select back to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zxto_i | input | 3 | Per-phase zero-crossing timeout flag (bit 0 A, 1 B, 2 C) |
| sag_i | input | 3 | Per-phase voltage sag flag (bit 0 A, 1 B, 2 C) |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | Register address: 0 source select, 1 zero-crossing enable |
| cfg_wdata_i | input | 8 | Register write data |
| freq_sel_o | output | 2 | Frequency-source phase: 00 A, 01 B, 10 C |
| zc_mask_o | output | 3 | Phases taking part in zero-crossing counting |
| src_switch_o | output | 1 | One-cycle pulse on an automatic source change |

## Verification
Each phase carries its own dropped mark. If that mark is wrong, the phase's mask bit shows it one cycle after the flag edge. A wrong mark on the selected phase also shows at the select one edge after that, as a move that is missing or not needed. A fault in the recovery counter shows as a mask bit that comes back one edge early or late around the RECOVER_CYC boundary, so the tests probe both sides of that edge. A fault in the search order shows only when two phases are dropped together or the search wraps past C. Directed cases set up exactly those conditions.

// File: rtl/pdo_pkg.sv
package pdo_pkg;
  localparam int NUM_PH = 3;
  localparam int SEL_W  = 2;

  localparam logic ADDR_SRC = 1'b0;
  localparam logic ADDR_ZC  = 1'b1;

  localparam int SEL_LSB = 0;
  localparam int ZC_LSB  = 3;

  typedef enum logic [SEL_W-1:0] {
    PH_A   = 2'b00,
    PH_B   = 2'b01,
    PH_C   = 2'b10,
    PH_RSV = 2'b11
  } ph_sel_e;

  function automatic ph_sel_e norm_sel(input logic [SEL_W-1:0] code);
    return (code == PH_RSV) ? PH_A : ph_sel_e'(code);
  endfunction
endpackage

// File: rtl/pdo_phase_track.sv
module pdo_phase_track #(
  parameter int RECOVER_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zxto_i,
  input  logic sag_i,
  output logic dropped_o
);
  localparam int CNT_W = $clog2(RECOVER_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RECOVER_CYC - 1);

  logic             bad;
  logic             dropped_q;
  logic [CNT_W-1:0] quiet_q;

  assign bad = zxto_i | sag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dropped_q <= 1'b0;
      quiet_q   <= '0;
    end else if (bad) begin
      dropped_q <= 1'b1;
      quiet_q   <= '0;
    end else if (dropped_q) begin
      if (quiet_q == CNT_LAST) begin
        dropped_q <= 1'b0;
        quiet_q   <= '0;
      end else begin
        quiet_q <= quiet_q + 1'b1;
      end
    end
  end

  assign dropped_o = dropped_q;
endmodule

// File: rtl/pdo_cfg_regs.sv
module pdo_cfg_regs
  import pdo_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic                cfg_addr_i,
  input  logic [7:0]          cfg_wdata_i,
  output logic                sel_wr_o,
  output ph_sel_e             sel_wdata_o,
  output logic [NUM_PH-1:0]   zc_en_o
);
  logic [NUM_PH-1:0] zc_en_q;
  logic              zc_wr;
  logic              unused_wdata;

  assign sel_wr_o    = cfg_we_i && (cfg_addr_i == ADDR_SRC);
  assign zc_wr       = cfg_we_i && (cfg_addr_i == ADDR_ZC);
  assign sel_wdata_o = norm_sel(cfg_wdata_i[SEL_LSB +: SEL_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zc_en_q <= '1;
    else if (zc_wr) zc_en_q <= cfg_wdata_i[ZC_LSB +: NUM_PH];
  end

  assign zc_en_o      = zc_en_q;
  assign unused_wdata = ^{cfg_wdata_i[7:ZC_LSB+NUM_PH], cfg_wdata_i[ZC_LSB-1:SEL_LSB+SEL_W]};
endmodule

// File: rtl/pdo_src_pick.sv
module pdo_src_pick
  import pdo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_wr_i,
  input  ph_sel_e           sel_wdata_i,
  input  logic [NUM_PH-1:0] dropped_i,
  output ph_sel_e           sel_o,
  output logic              switch_o
);
  ph_sel_e sel_q, sel_d, cand;
  logic    found, auto_d, switch_q;

  // cyclic search starting after the current phase
  always_comb begin
    found = 1'b0;
    cand  = sel_q;
    for (int k = 1; k < NUM_PH; k++) begin
      int c;
      c = (int'(sel_q) + k) % NUM_PH;
      if (!found && !dropped_i[c]) begin
        found = 1'b1;
        cand  = ph_sel_e'(c[SEL_W-1:0]);
      end
    end
  end

  always_comb begin
    sel_d  = sel_q;
    auto_d = 1'b0;
    if (sel_wr_i) begin
      sel_d = sel_wdata_i;
    end else if (dropped_i[sel_q] && found) begin
      sel_d  = cand;
      auto_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= PH_A;
      switch_q <= 1'b0;
    end else begin
      sel_q    <= sel_d;
      switch_q <= auto_d;
    end
  end

  assign sel_o    = sel_q;
  assign switch_o = switch_q;
endmodule

// File: rtl/phase_dropout_sup.sv
module phase_dropout_sup
  import pdo_pkg::*;
#(
  parameter int RECOVER_CYC = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  zxto_i,
  input  logic [2:0]  sag_i,
  input  logic        cfg_we_i,
  input  logic        cfg_addr_i,
  input  logic [7:0]  cfg_wdata_i,
  output logic [1:0]  freq_sel_o,
  output logic [2:0]  zc_mask_o,
  output logic        src_switch_o
);
  logic [NUM_PH-1:0] dropped;
  logic [NUM_PH-1:0] zc_en;
  logic              sel_wr;
  ph_sel_e           sel_wdata;
  ph_sel_e           sel;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    pdo_phase_track #(.RECOVER_CYC(RECOVER_CYC)) u_trk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .zxto_i    (zxto_i[p]),
      .sag_i     (sag_i[p]),
      .dropped_o (dropped[p])
    );
  end

  pdo_cfg_regs u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .sel_wr_o    (sel_wr),
    .sel_wdata_o (sel_wdata),
    .zc_en_o     (zc_en)
  );

  pdo_src_pick u_pick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_wr_i    (sel_wr),
    .sel_wdata_i (sel_wdata),
    .dropped_i   (dropped),
    .sel_o       (sel),
    .switch_o    (src_switch_o)
  );

  assign freq_sel_o = sel;
  assign zc_mask_o  = zc_en & ~dropped;
endmodule

// File: rtl/phase_dropout_sup_chk.sv
module phase_dropout_sup_chk
  import pdo_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] zxto_i,
  input logic [2:0] sag_i,
  input logic       cfg_we_i,
  input logic       cfg_addr_i,
  input logic [1:0] freq_sel_o,
  input logic [2:0] zc_mask_o,
  input logic       src_switch_o,
  input logic [2:0] dropped_i
);
  logic sel_wr, sel_dropped;
  assign sel_wr = cfg_we_i && (cfg_addr_i == ADDR_SRC);

  always_comb begin
    case (freq_sel_o)
      2'b00:   sel_dropped = dropped_i[0];
      2'b01:   sel_dropped = dropped_i[1];
      2'b10:   sel_dropped = dropped_i[2];
      default: sel_dropped = 1'b0;
    endcase
  end

  a_r3_sel_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_sel_o != 2'b11);

  a_r5_mask_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (($past(zxto_i | sag_i) & zc_mask_o) == 3'b000));

  a_r6_leave_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(sel_dropped) && !$past(&dropped_i) && !$past(sel_wr))
    |-> (freq_sel_o != $past(freq_sel_o)));

  a_r7_hold_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(&dropped_i) && !$past(sel_wr)) |-> $stable(freq_sel_o));

  a_r9_pulse_has_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_switch_o |-> (freq_sel_o != $past(freq_sel_o)));

  a_r9_change_has_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(sel_wr) && (freq_sel_o != $past(freq_sel_o))) |-> src_switch_o);

  a_r8_release_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((($past(dropped_i) & ~dropped_i) & $past(zxto_i | sag_i)) == 3'b000));
endmodule

bind phase_dropout_sup phase_dropout_sup_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .zxto_i       (zxto_i),
  .sag_i        (sag_i),
  .cfg_we_i     (cfg_we_i),
  .cfg_addr_i   (cfg_addr_i),
  .freq_sel_o   (freq_sel_o),
  .zc_mask_o    (zc_mask_o),
  .src_switch_o (src_switch_o),
  .dropped_i    (dropped)
);

// File: tb/phase_dropout_sup_tb_top.sv
module phase_dropout_sup_tb_top;
  localparam int RC = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] zxto = '0, sag = '0;
  logic       we = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [1:0] sel;
  logic [2:0] mask;
  logic       sw;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phase_dropout_sup #(.RECOVER_CYC(RC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .zxto_i(zxto), .sag_i(sag),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .freq_sel_o(sel), .zc_mask_o(mask), .src_switch_o(sw)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; zxto = '0; sag = '0; we = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    step(1);
    we = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 sel", 8'(sel), 8'h0);
    chk("R1 mask", 8'(mask), 8'h7);
    chk("R1 pulse", 8'(sw), 8'h0);
  endtask

  task automatic t_sw_write();
    do_reset();
    wr(1'b0, 8'h01);
    chk("R2 sel B", 8'(sel), 8'h1);
    chk("R9 no pulse on write", 8'(sw), 8'h0);
    wr(1'b0, 8'hFE);
    chk("R2 sel C", 8'(sel), 8'h2);
    wr(1'b0, 8'h03);
    chk("R3 reserved to A", 8'(sel), 8'h0);
    wr(1'b1, 8'hD0);  // bits[5:3] = 010
    chk("R4 zc set", 8'(mask), 8'h2);
    wr(1'b0, 8'h38);  // addr 0 must not touch zc set
    chk("R4 zc unchanged", 8'(mask), 8'h2);
    chk("R4 sel from addr0", 8'(sel), 8'h0);
  endtask

  task automatic t_failover_a();
    do_reset();
    zxto = 3'b001;
    step(1);
    chk("R5 mask A out", 8'(mask), 8'h6);
    chk("R6 sel not yet", 8'(sel), 8'h0);
    chk("R9 no pulse yet", 8'(sw), 8'h0);
    step(1);
    chk("R6 sel to B", 8'(sel), 8'h1);
    chk("R9 pulse", 8'(sw), 8'h1);
    step(1);
    chk("R9 pulse one cycle", 8'(sw), 8'h0);
    chk("R6 sel stays B", 8'(sel), 8'h1);
  endtask

  task automatic t_wrap_skip();
    do_reset();
    wr(1'b0, 8'h02);
    sag = 3'b100;
    step(2);
    chk("R6 wrap C to A", 8'(sel), 8'h0);
    chk("R9 wrap pulse", 8'(sw), 8'h1);
    do_reset();
    zxto = 3'b001; sag = 3'b010;
    step(2);
    chk("R6 skip to C", 8'(sel), 8'h2);
    chk("R5 mask A,B out", 8'(mask), 8'h4);
  endtask

  task automatic t_nonsel();
    do_reset();
    sag = 3'b010;
    step(3);
    chk("R10 sel kept", 8'(sel), 8'h0);
    chk("R10 no pulse", 8'(sw), 8'h0);
    chk("R5 mask B out", 8'(mask), 8'h5);
  endtask

  task automatic t_all();
    int pulses = 0;
    do_reset();
    wr(1'b0, 8'h01);
    zxto = 3'b101; sag = 3'b010;
    for (int i = 0; i < 5; i++) begin
      step(1);
      if (sw) pulses++;
    end
    chk("R7 sel held", 8'(sel), 8'h1);
    chk("R7 no pulse", 8'(pulses), 8'h0);
    chk("R5 mask empty", 8'(mask), 8'h0);
  endtask

  task automatic t_recover();
    do_reset();
    sag = 3'b010;
    step(1);
    sag = 3'b000;
    step(RC - 1);
    chk("R8 still dropped", 8'(mask), 8'h5);
    step(1);
    chk("R8 restored", 8'(mask), 8'h7);
    // restart on reassertion
    zxto = 3'b100;
    step(1);
    zxto = 3'b000;
    step(4);
    zxto = 3'b100;
    step(1);
    zxto = 3'b000;
    step(RC - 1);
    chk("R8 restart count", 8'(mask), 8'h3);
    step(1);
    chk("R8 restored after restart", 8'(mask), 8'h7);
    // recovered phase disabled by software stays masked
    wr(1'b1, 8'h18);  // enable A,B
    sag = 3'b100;
    step(1);
    sag = 3'b000;
    step(RC + 1);
    chk("R8 follows enable", 8'(mask), 8'h3);
  endtask

  task automatic t_no_failback();
    do_reset();
    zxto = 3'b001;
    step(1);
    zxto = 3'b000;
    step(RC + 3);
    chk("R12 A restored", 8'(mask), 8'h7);
    chk("R12 sel stays B", 8'(sel), 8'h1);
    chk("R12 no pulse", 8'(sw), 8'h0);
  endtask

  task automatic t_priority();
    do_reset();
    zxto = 3'b001;
    step(1);
    wr(1'b0, 8'h02);
    chk("R11 write wins", 8'(sel), 8'h2);
    chk("R11 no pulse", 8'(sw), 8'h0);
    wr(1'b0, 8'h00);  // write dropped A
    chk("R11 dropped written", 8'(sel), 8'h0);
    step(1);
    chk("R11 follows to B", 8'(sel), 8'h1);
    chk("R11 pulse", 8'(sw), 8'h1);
  endtask

  initial begin
    t_reset();
    t_sw_write();
    t_failover_a();
    t_wrap_skip();
    t_nonsel();
    t_all();
    t_recover();
    t_no_failback();
    t_priority();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule